// File: doc/BRIEF.md
# Low-Power Freeze Mode Controller

This block decides when a programmable-logic fabric enters and leaves a static low-power freeze state, and drives the controls that make the freeze safe. A freeze request arrives on an external pin. An optional second request comes from user logic. A strap selects whether the pin alone is enough to enter, or whether both requests are needed. Leaving the freeze always depends on the pin alone. Entry is also held off until power is reported good, so a request that is already present at power-up takes effect only after supply start-up.

While frozen, the block does the following:
- It powers down the PLL and stops the fabric clock.
- It blocks JTAG operations.
- It forces every pad into its freeze state. Output drivers are disabled and weak pulls are kept. Values seen by the core from input buffers are forced high.

Entry and exit each finish within a fixed number of clock cycles set by parameters. All controls are plain level signals; there is no streaming data path.

Top module: `freeze_ctrl`

## Requirements
- R1: With `mode_both`=0, a high `frz_req_pin` sampled on a rising edge makes `frozen` rise within ENTRY_CYC+3 rising edges, counting that edge, whatever `usr_frz_req` is.
- R2: With `mode_both`=1, the block freezes only while both `frz_req_pin` and `usr_frz_req` are high. The pin alone never freezes it.
- R3: Once frozen, the block stays frozen while `frz_req_pin` is high, whatever `usr_frz_req` does. After the pin goes low, `frozen` falls within EXIT_CYC+4 rising edges, in either mode.
- R4: While `pwr_good` is low, the block does not enter the freeze, even if the request conditions hold. Entry follows once `pwr_good` rises.
- R5: `pll_pwrdn` equals `frozen` and `clk_run` is its inverse. The PLL controls and the pad forcing change in the same cycle.
- R6: Pad kind encoding per 2-bit field i of `pad_kind`: 00 input, 01 output, 10 tristate output, 11 bidirectional. When not frozen, `pad_drv_en[i]` takes these values: 1 for output, `pad_oe[i]` for tristate and bidirectional, 0 for input. When frozen, it is 0 for every pad.
- R7: In both states, `pad_pu_en[i]` = `pad_pull_en[i]` & `pad_pull_up[i]`, and `pad_pd_en[i]` = `pad_pull_en[i]` & ~`pad_pull_up[i]`.
- R8: `core_in_val[i]` is 0 for output and tristate-output pads. For input pads, and for bidirectional pads with `pad_oe[i]`=0, it is 1 while frozen and `pad_in_val[i]` otherwise. For bidirectional pads with `pad_oe[i]`=1, it is always `pad_in_val[i]`.
- R9: `jtag_block` is high exactly while `frozen` is high, and is low out of reset.
- R10: `cfg_err` rises one cycle after `req_pin_pull_en` is high (a weak pull on the request pin is illegal) and falls one cycle after it goes low.
- R11: If the entry condition drops before the entry delay completes, the block returns to running and does not freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frz_req_pin | input | 1 | External freeze request, asynchronous |
| usr_frz_req | input | 1 | Freeze request from user logic, asynchronous |
| mode_both | input | 1 | Strap: 1 = entry needs both requests |
| pwr_good | input | 1 | Supplies stable |
| req_pin_pull_en | input | 1 | Weak pull configured on the request pin |
| pad_kind | input | 2*NPAD | Buffer kind per pad |
| pad_oe | input | NPAD | Output enable per pad |
| pad_pull_en | input | NPAD | Weak pull enable per pad |
| pad_pull_up | input | NPAD | Pull direction, 1 = up |
| pad_in_val | input | NPAD | Value from each pad input buffer |
| pll_pwrdn | output | 1 | PLL power-down |
| clk_run | output | 1 | Fabric clock gate enable |
| pad_drv_en | output | NPAD | Output driver enable per pad |
| pad_pu_en | output | NPAD | Weak pull-up enable per pad |
| pad_pd_en | output | NPAD | Weak pull-down enable per pad |
| core_in_val | output | NPAD | Value presented to the core per pad |
| jtag_block | output | 1 | JTAG operations blocked |
| frozen | output | 1 | Freeze state |
| cfg_err | output | 1 | Illegal pull on request pin |

## Verification
The bench targets these cases:
- Mode 2 with only the pin high. A design that ignored the second request would freeze there.
- Dropping the user request while frozen. A design that let that request take part in exit would wake early.
- A request held before power is good. A design missing the power gate would freeze during start-up.
- A request pulse shorter than the entry delay. A design whose counter ran on would freeze anyway.
- Random pad configurations in both states, including bidirectional pads in input mode. These catch a core value not forced high, or a driver left enabled while frozen.

// File: rtl/freeze_pkg.sv
package freeze_pkg;

  typedef enum logic [1:0] {
    PK_IN    = 2'b00,
    PK_OUT   = 2'b01,
    PK_TRI   = 2'b10,
    PK_BIDIR = 2'b11
  } pad_kind_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_ARM,
    ST_FROZEN,
    ST_WAKE
  } fz_state_e;

  typedef struct packed {
    logic drv;
    logic pu;
    logic pd;
    logic core;
  } pad_ctl_t;

  function automatic pad_ctl_t map_pad(
    input logic [1:0] kind,
    input logic       oe,
    input logic       pen,
    input logic       pup,
    input logic       in_val,
    input logic       frz
  );
    pad_ctl_t c;
    c.pu = pen & pup;
    c.pd = pen & ~pup;
    case (pad_kind_e'(kind))
      PK_IN: begin
        c.drv  = 1'b0;
        c.core = frz ? 1'b1 : in_val;
      end
      PK_OUT: begin
        c.drv  = ~frz;
        c.core = 1'b0;
      end
      PK_TRI: begin
        c.drv  = oe & ~frz;
        c.core = 1'b0;
      end
      default: begin
        c.drv  = oe & ~frz;
        c.core = (frz & ~oe) ? 1'b1 : in_val;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fz_sync.sv
module fz_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fz_seq.sv
module fz_seq
  import freeze_pkg::*;
#(
  parameter int ENTRY_CYC = 4,
  parameter int EXIT_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic usr_s,
  input  logic mode_both,
  input  logic pwr_good,
  output logic frozen
);
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  fz_state_e st;
  logic [CW-1:0] cnt;
  logic entry_ok;

  assign entry_ok = pwr_good & pin_s & (~mode_both | usr_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (entry_ok) begin
            st  <= ST_ARM;
            cnt <= '0;
          end
        end
        ST_ARM: begin
          if (!entry_ok) st <= ST_RUN;
          else if (cnt == CW'(ENTRY_CYC-1)) st <= ST_FROZEN;
          else cnt <= cnt + 1'b1;
        end
        ST_FROZEN: begin
          if (!pin_s) begin
            st  <= ST_WAKE;
            cnt <= '0;
          end
        end
        default: begin
          if (pin_s) st <= ST_FROZEN;
          else if (cnt == CW'(EXIT_CYC-1)) st <= ST_RUN;
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign frozen = (st == ST_FROZEN) || (st == ST_WAKE);
endmodule

// File: rtl/fz_pad_map.sv
module fz_pad_map
  import freeze_pkg::*;
#(
  parameter int NPAD = 8
) (
  input  logic              frz,
  input  logic [2*NPAD-1:0] kind,
  input  logic [NPAD-1:0]   oe,
  input  logic [NPAD-1:0]   pull_en,
  input  logic [NPAD-1:0]   pull_up,
  input  logic [NPAD-1:0]   in_val,
  output logic [NPAD-1:0]   drv_en,
  output logic [NPAD-1:0]   pu_en,
  output logic [NPAD-1:0]   pd_en,
  output logic [NPAD-1:0]   core_val
);
  generate
    for (genvar i = 0; i < NPAD; i++) begin : g_pad
      pad_ctl_t c;
      always_comb begin
        c = map_pad(kind[2*i +: 2], oe[i], pull_en[i], pull_up[i], in_val[i], frz);
      end
      assign drv_en[i]   = c.drv;
      assign pu_en[i]    = c.pu;
      assign pd_en[i]    = c.pd;
      assign core_val[i] = c.core;
    end
  endgenerate
endmodule

// File: rtl/freeze_ctrl.sv
module freeze_ctrl #(
  parameter int NPAD        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 4,
  parameter int EXIT_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frz_req_pin,
  input  logic              usr_frz_req,
  input  logic              mode_both,
  input  logic              pwr_good,
  input  logic              req_pin_pull_en,
  input  logic [2*NPAD-1:0] pad_kind,
  input  logic [NPAD-1:0]   pad_oe,
  input  logic [NPAD-1:0]   pad_pull_en,
  input  logic [NPAD-1:0]   pad_pull_up,
  input  logic [NPAD-1:0]   pad_in_val,
  output logic              pll_pwrdn,
  output logic              clk_run,
  output logic [NPAD-1:0]   pad_drv_en,
  output logic [NPAD-1:0]   pad_pu_en,
  output logic [NPAD-1:0]   pad_pd_en,
  output logic [NPAD-1:0]   core_in_val,
  output logic              jtag_block,
  output logic              frozen,
  output logic              cfg_err
);
  logic [1:0] req_s;
  logic pin_s, usr_s, frz_i;

  fz_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({usr_frz_req, frz_req_pin}), .q(req_s)
  );
  assign pin_s = req_s[0];
  assign usr_s = req_s[1];

  fz_seq #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .usr_s(usr_s),
    .mode_both(mode_both), .pwr_good(pwr_good), .frozen(frz_i)
  );

  fz_pad_map #(.NPAD(NPAD)) u_pads (
    .frz(frz_i), .kind(pad_kind), .oe(pad_oe), .pull_en(pad_pull_en),
    .pull_up(pad_pull_up), .in_val(pad_in_val), .drv_en(pad_drv_en),
    .pu_en(pad_pu_en), .pd_en(pad_pd_en), .core_val(core_in_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else cfg_err <= req_pin_pull_en;
  end

  assign frozen     = frz_i;
  assign pll_pwrdn  = frz_i;
  assign clk_run    = ~frz_i;
  assign jtag_block = frz_i;
endmodule

// File: rtl/freeze_ctrl_chk.sv
module freeze_ctrl_chk #(
  parameter int NPAD      = 8,
  parameter int ENTRY_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pin_s,
  input logic            usr_s,
  input logic            mode_both,
  input logic            pwr_good,
  input logic            frozen,
  input logic            pll_pwrdn,
  input logic            jtag_block,
  input logic [NPAD-1:0] pad_drv_en
);
  logic ok;
  logic [15:0] wait_cnt;
  assign ok = pwr_good & pin_s & (~mode_both | usr_s);

  always_ff @(posedge clk) begin
    if (!rst_n) wait_cnt <= '0;
    else if (!frozen && ok) wait_cnt <= wait_cnt + 1'b1;
    else wait_cnt <= '0;
  end

  AST_MODE2_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && mode_both && !usr_s) |=> !frozen); // R2
  AST_EXIT_PIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && pin_s) |=> frozen); // R3
  AST_PWR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !pwr_good) |=> !frozen); // R4
  AST_PLL_WITH_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> (pad_drv_en == '0)); // R5
  AST_JTAG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_block == frozen)); // R9
  AST_ENTRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt <= 16'(ENTRY_CYC + 1))); // R1
  AST_ABORT_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !ok) |=> !frozen); // R11
endmodule

bind freeze_ctrl freeze_ctrl_chk #(.NPAD(NPAD), .ENTRY_CYC(ENTRY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .usr_s(usr_s),
  .mode_both(mode_both), .pwr_good(pwr_good), .frozen(frozen),
  .pll_pwrdn(pll_pwrdn), .jtag_block(jtag_block), .pad_drv_en(pad_drv_en)
);

// File: tb/sim_freeze_ctrl.sv
`timescale 1ns/1ps
module sim_freeze_ctrl;
  localparam int NPAD = 8;
  localparam int ENTRY_CYC = 4;
  localparam int EXIT_CYC = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic frz_req_pin, usr_frz_req, mode_both, pwr_good, req_pin_pull_en;
  logic [2*NPAD-1:0] pad_kind;
  logic [NPAD-1:0] pad_oe, pad_pull_en, pad_pull_up, pad_in_val;
  logic pll_pwrdn, clk_run, jtag_block, frozen, cfg_err;
  logic [NPAD-1:0] pad_drv_en, pad_pu_en, pad_pd_en, core_in_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  freeze_ctrl #(.NPAD(NPAD), .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected pad outputs packed as {drv, pu, pd, core}
  function automatic logic [3:0] exp_pad(input logic [1:0] k, input logic oe,
      input logic pe, input logic up, input logic iv, input logic fz);
    logic drv, core;
    case (k)
      2'b00: begin drv = 1'b0; core = fz ? 1'b1 : iv; end
      2'b01: begin drv = !fz; core = 1'b0; end
      2'b10: begin drv = fz ? 1'b0 : oe; core = 1'b0; end
      default: begin drv = fz ? 1'b0 : oe; core = oe ? iv : (fz ? 1'b1 : iv); end
    endcase
    return {drv, pe && up, pe && !up, core};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_frz(input logic want, input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); #1;
      if (frozen === want) begin hit = 1; break; end
    end
  endtask

  task automatic pad_round(input logic fz, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      pad_kind = 16'($urandom); pad_oe = 8'($urandom);
      pad_pull_en = 8'($urandom); pad_pull_up = 8'($urandom); pad_in_val = 8'($urandom);
      #1;
      for (int i = 0; i < NPAD; i++) begin
        logic [3:0] e;
        e = exp_pad(pad_kind[2*i +: 2], pad_oe[i], pad_pull_en[i], pad_pull_up[i], pad_in_val[i], fz);
        chk("R6 drv", pad_drv_en[i], e[3]);
        chk("R7 pulls", {pad_pu_en[i], pad_pd_en[i]}, e[2:1]);
        chk("R8 core", core_in_val[i], e[0]);
      end
    end
  endtask

  task automatic no_frz_for(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (frozen !== 1'b0) begin chk(tag, frozen, 0); return; end
    end
    chk(tag, frozen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit hit;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 0; frz_req_pin = 0; usr_frz_req = 0; mode_both = 0; pwr_good = 1;
    req_pin_pull_en = 0; pad_kind = '0; pad_oe = '0; pad_pull_en = '0;
    pad_pull_up = '0; pad_in_val = '0;
    cycles(4);
    @(negedge clk) rst_n = 1;
    cycles(2);
    chk("R9 reset frozen", frozen, 0);
    chk("R5 reset pll", {pll_pwrdn, clk_run}, 2'b01);
    chk("R9 reset jtag", jtag_block, 0);
    chk("R10 reset cfg_err", cfg_err, 0);

    // R10
    @(negedge clk) req_pin_pull_en = 1;
    @(posedge clk); #1;
    chk("R10 cfg_err set", cfg_err, 1);
    @(negedge clk) req_pin_pull_en = 0;
    @(posedge clk); #1;
    chk("R10 cfg_err clear", cfg_err, 0);

    pad_round(1'b0, 30);

    // R1: pin alone, user request low
    @(negedge clk) frz_req_pin = 1;
    wait_frz(1'b1, ENTRY_CYC + 3, hit);
    chk("R1 entry bound", hit, 1);
    chk("R5 pll down clock stopped", {pll_pwrdn, clk_run}, 2'b10);
    chk("R9 jtag blocked", jtag_block, 1);
    pad_round(1'b1, 30);

    // R3: user request toggles, no exit
    @(negedge clk) usr_frz_req = 1;
    cycles(5);
    @(negedge clk) usr_frz_req = 0;
    cycles(10);
    chk("R3 usr no exit", frozen, 1);
    @(negedge clk) frz_req_pin = 0;
    wait_frz(1'b0, EXIT_CYC + 4, hit);
    chk("R3 exit bound mode1", hit, 1);
    chk("R9 jtag released", jtag_block, 0);

    // R2: mode 2
    @(negedge clk) begin mode_both = 1; frz_req_pin = 1; end
    no_frz_for("R2 pin alone", 20);
    @(negedge clk) usr_frz_req = 1;
    wait_frz(1'b1, ENTRY_CYC + 3, hit);
    chk("R2 both entry", hit, 1);
    @(negedge clk) usr_frz_req = 0;
    cycles(12);
    chk("R3 usr drop mode2", frozen, 1);
    @(negedge clk) frz_req_pin = 0;
    wait_frz(1'b0, EXIT_CYC + 4, hit);
    chk("R3 exit bound mode2", hit, 1);

    // R4: power-good gating
    @(negedge clk) begin mode_both = 0; pwr_good = 0; frz_req_pin = 1; end
    no_frz_for("R4 held off", 25);
    @(negedge clk) pwr_good = 1;
    wait_frz(1'b1, ENTRY_CYC + 3, hit);
    chk("R4 entry after pwr_good", hit, 1);
    @(negedge clk) frz_req_pin = 0;
    wait_frz(1'b0, EXIT_CYC + 4, hit);
    chk("R3 exit after R4", hit, 1);

    // R11: short pulses abort
    for (int p = 1; p <= ENTRY_CYC; p++) begin
      @(negedge clk) frz_req_pin = 1;
      repeat (p) @(negedge clk);
      frz_req_pin = 0;
      no_frz_for("R11 short pulse", 15);
    end

    // random request sequences: pin low keeps the block awake after the exit delay
    for (int r = 0; r < 20; r++) begin
      @(negedge clk) begin
        mode_both = 1'($urandom); usr_frz_req = 1'($urandom); frz_req_pin = 1;
      end
      if (!mode_both || usr_frz_req) begin
        wait_frz(1'b1, ENTRY_CYC + 3, hit);
        chk("R1 random entry", hit, 1);
        pad_round(1'b1, 2);
      end else begin
        no_frz_for("R2 random pin alone", ENTRY_CYC + 6);
      end
      @(negedge clk) begin frz_req_pin = 0; usr_frz_req = 1'($urandom); end
      wait_frz(1'b0, EXIT_CYC + 4, hit);
      chk("R3 random exit", hit, 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule